// File: doc/BRIEF.md
# Shared Bus Yield Controller

This block lives in a processor's external memory interface and lets an outside arbiter take a shared external bus away from the processor. While the processor owns the bus, external access requests from the core are launched onto it. An access runs until the bus raises its ready input. When the arbiter raises `bus_req`, the block never cuts off a transfer that is already running. It waits for that transfer to finish, turns off its output enables so the bus floats, and then raises `bus_gnt`.

While the bus is handed over, the core keeps running. It is stalled only when it asks for an external access. When `bus_req` drops, the block first removes `bus_gnt` for one cycle with its drivers still off, then drives the bus again. Any waiting access then proceeds.

The controller has four states:
- **OWNED**: drivers on, no grant.
- **FINISHING**: drivers on, no grant, a transfer still completing.
- **RELEASED**: drivers off, grant high.
- **RECLAIM**: drivers off, grant low, for one cycle.

Its transitions are:
- OWNED→FINISHING: request while a transfer is running and not yet ready.
- OWNED→RELEASED: request while no transfer is pending, or on the transfer's ready cycle.
- FINISHING→RELEASED: ready while the request is still high.
- FINISHING→OWNED: request withdrawn before the transfer ends.
- RELEASED→RECLAIM: request falls.
- RECLAIM→OWNED: always, after one cycle.

Top module: `busyield_ctrl`

## Requirements
- R1: After reset the block is in OWNED: `ext_oe`=1, `bus_gnt`=0, `ext_strobe`=0.
- R2: In OWNED with `bus_req` low and no transfer running, a high `core_req` starts a transfer. On the next cycle `ext_strobe`=1, and `ext_addr`, `ext_wdata` and `ext_we` hold the core's values from the start cycle. These values stay constant until the transfer ends.
- R3: A transfer ends in the cycle where `ext_strobe` and `ext_ready` are both high. In that cycle `core_done`=1 and `core_rdata` equals `ext_rdata`. On the next cycle `ext_strobe`=0.
- R4: In OWNED with no transfer running, or with the running transfer ending this cycle, a high `bus_req` moves the block to RELEASED on the next cycle: `bus_gnt`=1 and `ext_oe`=0.
- R5: A `bus_req` that arrives while a transfer is running and not ready moves the block to FINISHING. In FINISHING, `ext_oe` stays 1, `bus_gnt` stays 0 and `ext_strobe` stays 1 until `ext_ready`. The block enters RELEASED on the cycle after ready.
- R6: No transfer starts in any cycle where `bus_req` is high, including the cycle in which it first rises.
- R7: `core_stall` equals `core_req` AND NOT `core_done`. In RELEASED a requesting core is therefore stalled and no strobe is issued, while a core that does not request is not stalled.
- R8: When `bus_req` falls in RELEASED, the next cycle is RECLAIM with `bus_gnt`=0 and `ext_oe`=0. OWNED with `ext_oe`=1 follows one cycle later.
- R9: If `bus_req` falls while in FINISHING, the block returns to OWNED without ever raising `bus_gnt`. The running transfer continues.
- R10: `bus_gnt` and `ext_oe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core wants an external access (held until done) |
| core_we | input | 1 | Access is a write |
| core_addr | input | AW | Access address |
| core_wdata | input | DW | Write data |
| core_stall | output | 1 | Core must wait |
| core_done | output | 1 | Access completes this cycle |
| core_rdata | output | DW | Read data, valid with core_done |
| ext_addr | output | AW | Bus address |
| ext_wdata | output | DW | Bus write data |
| ext_we | output | 1 | Bus write strobe qualifier |
| ext_strobe | output | 1 | Bus access in progress |
| ext_oe | output | 1 | Output enable for address, data and strobe drivers |
| ext_rdata | input | DW | Bus read data |
| ext_ready | input | 1 | Bus access finishes this cycle |
| bus_req | input | 1 | Arbiter asks for the bus |
| bus_gnt | output | 1 | Bus has been released |

## Verification
Two events can land on the same clock edge, and both overlaps are provoked on purpose.

The first overlap is a new core request arriving in the same cycle that `bus_req` rises. The bench expects the hand-over to win: no strobe follows, the grant appears, and the core stays stalled until RECLAIM has passed.

The second overlap is `ext_ready` arriving together with a change of `bus_req`. This covers ready while OWNED with `bus_req` rising, and ready while FINISHING with `bus_req` falling. The bench expects the transfer to complete exactly once. The next state must be RELEASED in the first case and OWNED in the second.

Both overlaps, and many chance ones from random traffic, are judged against a behavioural model on every cycle.

// File: rtl/byl_pkg.sv
package byl_pkg;
    typedef enum logic [1:0] {
        ST_OWNED     = 2'd0,
        ST_FINISHING = 2'd1,
        ST_RELEASED  = 2'd2,
        ST_RECLAIM   = 2'd3
    } byl_state_t;
endpackage

// File: rtl/byl_fsm.sv
module byl_fsm
    import byl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_req,
    input  logic       xfer_busy,
    input  logic       xfer_done,
    output byl_state_t state,
    output logic       gnt,
    output logic       oe,
    output logic       start_ok
);
    byl_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OWNED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OWNED: begin
                if (bus_req) begin
                    if (xfer_busy && !xfer_done) state_nx = ST_FINISHING;
                    else                         state_nx = ST_RELEASED;
                end
            end
            ST_FINISHING: begin
                if (!bus_req)       state_nx = ST_OWNED;
                else if (xfer_done) state_nx = ST_RELEASED;
            end
            ST_RELEASED: begin
                if (!bus_req) state_nx = ST_RECLAIM;
            end
            ST_RECLAIM: state_nx = ST_OWNED;
            default:    state_nx = ST_OWNED;
        endcase
    end

    always_comb begin
        gnt      = 1'b0;
        oe       = 1'b0;
        start_ok = 1'b0;
        unique case (state)
            ST_OWNED: begin
                oe       = 1'b1;
                start_ok = !bus_req;
            end
            ST_FINISHING: oe  = 1'b1;
            ST_RELEASED:  gnt = 1'b1;
            ST_RECLAIM:   ;
            default:      ;
        endcase
    end
endmodule

// File: rtl/byl_xfer.sv
module byl_xfer #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_ok,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    input  logic          ext_ready,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          we_q
);
    logic launch;

    assign done   = busy && ext_ready;
    assign launch = start_ok && core_req && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (launch) begin
            busy    <= 1'b1;
            addr_q  <= core_addr;
            wdata_q <= core_wdata;
            we_q    <= core_we;
        end
    end
endmodule

// File: rtl/busyield_ctrl.sv
module busyield_ctrl
    import byl_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_stall,
    output logic          core_done,
    output logic [DW-1:0] core_rdata,
    output logic [AW-1:0] ext_addr,
    output logic [DW-1:0] ext_wdata,
    output logic          ext_we,
    output logic          ext_strobe,
    output logic          ext_oe,
    input  logic [DW-1:0] ext_rdata,
    input  logic          ext_ready,
    input  logic          bus_req,
    output logic          bus_gnt
);
    byl_state_t state;
    logic       start_ok;
    logic       busy;
    logic       done;

    byl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .xfer_busy (busy),
        .xfer_done (done),
        .state     (state),
        .gnt       (bus_gnt),
        .oe        (ext_oe),
        .start_ok  (start_ok)
    );

    byl_xfer #(.AW(AW), .DW(DW)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok   (start_ok),
        .core_req   (core_req),
        .core_we    (core_we),
        .core_addr  (core_addr),
        .core_wdata (core_wdata),
        .ext_ready  (ext_ready),
        .busy       (busy),
        .done       (done),
        .addr_q     (ext_addr),
        .wdata_q    (ext_wdata),
        .we_q       (ext_we)
    );

    assign ext_strobe = busy;
    assign core_done  = done;
    assign core_stall = core_req && !done;
    assign core_rdata = ext_rdata;
endmodule

// File: rtl/byl_chk.sv
module byl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_req,
    input logic          core_stall,
    input logic          core_done,
    input logic [AW-1:0] ext_addr,
    input logic          ext_strobe,
    input logic          ext_oe,
    input logic          ext_ready,
    input logic          bus_req,
    input logic          bus_gnt
);
    // R10
    gnt_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_gnt && ext_oe));

    // R8
    reclaim_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_gnt) |-> !ext_oe);

    // R5
    no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_strobe && !ext_ready) |=> ext_strobe);

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_strobe && !ext_ready) |=> $stable(ext_addr));

    // R6
    no_start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_strobe) |-> !$past(bus_req));

    // R4
    grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> !ext_strobe);

    // R7
    released_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_gnt && core_req) |-> core_stall);

    // R3
    done_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |-> (ext_strobe && ext_ready));
endmodule

bind busyield_ctrl byl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_req   (core_req),
    .core_stall (core_stall),
    .core_done  (core_done),
    .ext_addr   (ext_addr),
    .ext_strobe (ext_strobe),
    .ext_oe     (ext_oe),
    .ext_ready  (ext_ready),
    .bus_req    (bus_req),
    .bus_gnt    (bus_gnt)
);

// File: tb/sim_busyield_ctrl.sv
`timescale 1ns/1ps
module sim_busyield_ctrl;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          core_req = 1'b0;
    logic          core_we = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic          core_stall, core_done, ext_we, ext_strobe, ext_oe, bus_gnt;
    logic [DW-1:0] core_rdata, ext_wdata;
    logic [AW-1:0] ext_addr;
    logic [DW-1:0] ext_rdata = '0;
    logic          ext_ready = 1'b0;
    logic          bus_req = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string phase = "R1";

    // behavioural reference: 0 owned, 1 finishing, 2 released, 3 reclaim
    int            m_st = 0;
    bit            m_busy = 0;
    bit [AW-1:0]   m_addr = '0;
    bit [DW-1:0]   m_wd = '0;
    bit            m_we = 0;

    always #10 clk = ~clk;

    busyield_ctrl #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_stall(core_stall),
        .core_done(core_done), .core_rdata(core_rdata), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_we(ext_we), .ext_strobe(ext_strobe),
        .ext_oe(ext_oe), .ext_rdata(ext_rdata), .ext_ready(ext_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_busy = 0; m_addr = '0; m_wd = '0; m_we = 0;
        end else begin
            bit fin;
            bit go;
            fin = m_busy && ext_ready;
            go  = (m_st == 0) && !bus_req && !m_busy && core_req;
            if (m_st == 0) begin
                if (bus_req) m_st = (m_busy && !ext_ready) ? 1 : 2;
            end else if (m_st == 1) begin
                if (!bus_req) m_st = 0;
                else if (fin) m_st = 2;
            end else if (m_st == 2) begin
                if (!bus_req) m_st = 3;
            end else begin
                m_st = 0;
            end
            if (fin) m_busy = 0;
            else if (go) begin
                m_busy = 1; m_addr = core_addr; m_wd = core_wdata; m_we = core_we;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", phase, tag, act, exp);
        end
    endtask

    task automatic compare();
        bit exp_done;
        exp_done = m_busy && ext_ready;
        chk("R4 bus_gnt", bus_gnt, m_st == 2);
        chk("R8 ext_oe", ext_oe, m_st <= 1);
        chk("R2 ext_strobe", ext_strobe, m_busy);
        chk("R3 core_done", core_done, exp_done);
        chk("R7 core_stall", core_stall, core_req && !exp_done);
        chk("R10 gnt_oe_excl", bus_gnt && ext_oe, 0);
        if (m_busy) begin
            chk("R2 ext_addr", ext_addr, m_addr);
            chk("R2 ext_wdata", ext_wdata, m_wd);
            chk("R2 ext_we", ext_we, m_we);
        end
        if (exp_done) chk("R3 core_rdata", core_rdata, ext_rdata);
    endtask

    // compare at falling edge, then drive the next cycle's inputs
    task automatic step(input bit rq, input bit br, input bit rdy, input int tag_addr);
        @(negedge clk);
        compare();
        core_req   = rq;
        bus_req    = br;
        ext_ready  = rdy;
        core_addr  = AW'(tag_addr);
        core_wdata = DW'(tag_addr * 3 + 1);
        core_we    = tag_addr[0];
        ext_rdata  = DW'(tag_addr ^ 16'h5a5a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1 ext_oe", ext_oe, 1);
        chk("R1 bus_gnt", bus_gnt, 0);
        chk("R1 ext_strobe", ext_strobe, 0);

        // R2/R3: plain access, two wait cycles
        phase = "R2";
        step(1, 0, 0, 16'h1234);
        step(1, 0, 0, 16'h1234);
        step(1, 0, 0, 16'h1234);
        phase = "R3";
        step(1, 0, 1, 16'h1234);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // R4: request while idle, R7 stalled core, R8 reclaim
        phase = "R4";
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        phase = "R7";
        step(0, 1, 0, 0);
        step(1, 1, 0, 16'h0042);
        step(1, 1, 0, 16'h0042);
        phase = "R8";
        step(1, 0, 0, 16'h0042);
        step(1, 0, 0, 16'h0042);
        step(1, 0, 0, 16'h0042);
        step(1, 0, 1, 16'h0042);
        step(0, 0, 0, 0);

        // R5: request during a transfer, finish, then release
        phase = "R5";
        step(1, 0, 0, 16'h0300);
        step(1, 0, 0, 16'h0300);
        step(1, 1, 0, 16'h0300);
        step(1, 1, 0, 16'h0300);
        step(1, 1, 1, 16'h0300);
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // R6: core request and bus request rise together
        phase = "R6";
        step(1, 1, 0, 16'h0777);
        step(1, 1, 0, 16'h0777);
        step(1, 1, 0, 16'h0777);
        step(1, 0, 0, 16'h0777);
        step(1, 0, 0, 16'h0777);
        step(1, 0, 0, 16'h0777);
        step(1, 0, 1, 16'h0777);
        step(0, 0, 0, 0);

        // R9: request withdrawn in FINISHING, ready coincides with the fall
        phase = "R9";
        step(1, 0, 0, 16'h0900);
        step(1, 0, 0, 16'h0900);
        step(1, 1, 0, 16'h0900);
        step(1, 1, 0, 16'h0900);
        step(1, 0, 1, 16'h0900);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // R4 corner: ready arrives on the cycle bus_req rises in OWNED
        phase = "R4";
        step(1, 0, 0, 16'h0a0a);
        step(1, 0, 0, 16'h0a0a);
        step(1, 1, 1, 16'h0a0a);
        step(0, 1, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);

        // mixed random traffic, core holds its request until done
        phase = "RND";
        begin
            bit rq = 0;
            int a = 0;
            for (int i = 0; i < 4000; i++) begin
                bit br, rdy;
                bit fin_now;
                fin_now = m_busy && ext_ready;
                if (!rq || fin_now) begin
                    rq = ($urandom_range(0, 2) != 0);
                    a  = int'($urandom_range(0, 65535));
                end
                br  = (i % 64 < 20) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 7) == 0);
                rdy = ($urandom_range(0, 2) == 0);
                step(rq, br, rdy, a);
            end
        end
        step(0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule